// File: doc/BRIEF.md
# Trigger Inhibit and Null-Event Controller

This block takes the level-1 trigger before it reaches the front-end readout chain. On every trigger it attaches a 12-bit bunch-crossing number and an 8-bit event number, and it writes that tag into a trigger queue. When the trigger is accepted, the block also sends it on to a group of front-end chips. The queue storage itself is outside the block. The block only drives the write strobe and the tag data.

When the inhibit function is enabled and any downstream buffer reports that it is almost full, the block stops sending triggers to the front end until that buffer has drained. A blocked trigger is not lost. It is still written into the queue, marked as a null event, and the event number still advances. The readout therefore emits an empty record in its place, and the event sequence stays aligned with the trigger count. When inhibit is disabled, triggers are always forwarded. A trigger that arrives while the trigger queue is full then latches a sticky overflow error.

A resync clears both numbers. A bunch-zero marker clears only the bunch-crossing number. Both clears take effect on the cycle they are asserted, so a trigger in that same cycle already carries the cleared values.

Top module: `trig_gate_ctrl`

## Requirements
- R1: After reset, every output is 0: `fe_trig_o`, `push_o`, `push_bc_o`, `push_ec_o`, `push_null_o`, `inhibit_o` and `ovf_err_o`.
- R2: The bunch-crossing number advances by one every clock cycle. After the value BC_PERIOD-1 (3563) it returns to 0. A trigger arriving k cycles after a bunch-zero cycle is tagged k.
- R3: Both numbers are cleared by `resync_i`. Only the bunch-crossing number is cleared by `bc_zero_i`, and the event number keeps counting. A trigger on the same cycle as the clear is tagged with the cleared value 0.
- R4: Each trigger cycle raises `push_o` for one cycle, on the cycle after the trigger. That push carries the trigger's bunch and event numbers in `push_bc_o` and `push_ec_o`. The event number then advances by one and wraps from 255 to 0.
- R5: An accepted trigger drives all NFE bits of `fe_trig_o` high on the cycle after the trigger, with `push_null_o` = 0.
- R6: `inhibit_o` goes high one cycle after a cycle in which `inhibit_en_i` is 1 and any bit of `almost_full_i` is 1. It goes low one cycle after that condition goes away.
- R7: A trigger that arrives while `inhibit_o` is high sends nothing to the front end (`fe_trig_o` = 0). It is still pushed, with `push_null_o` = 1, and it still advances the event number.
- R8: A trigger on the same cycle in which almost-full first rises is still forwarded, because the inhibit decision is registered.
- R9: While `inhibit_en_i` = 0, `almost_full_i` has no effect: `inhibit_o` stays 0 and triggers are forwarded.
- R10: A trigger with `inhibit_en_i` = 0 and `trigq_full_i` = 1 sets `ovf_err_o` on the next cycle, and it stays set until reset. With inhibit enabled, a full queue does not set the error.
- R11: On a cycle without a trigger, the next cycle has `push_o` = 0 and `fe_trig_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1a_i | input | 1 | Level-1 trigger, one per cycle |
| resync_i | input | 1 | Clears bunch and event numbers |
| bc_zero_i | input | 1 | Bunch-zero marker, clears the bunch number |
| inhibit_en_i | input | 1 | Enables trigger gating by almost-full |
| almost_full_i | input | NAF | Almost-full flags from the downstream buffers |
| trigq_full_i | input | 1 | Trigger queue full |
| fe_trig_o | output | NFE | Trigger sent to each front-end chip |
| push_o | output | 1 | Trigger queue write strobe |
| push_bc_o | output | 12 | Bunch-crossing number of the pushed trigger |
| push_ec_o | output | 8 | Event number of the pushed trigger |
| push_null_o | output | 1 | Pushed entry is a null (inhibited) event |
| inhibit_o | output | 1 | Trigger gating currently active |
| ovf_err_o | output | 1 | Sticky trigger-queue overflow error |

## Verification
Tagging a trigger and clearing the counts can fall in the same cycle. The bench drives `l1a_i` together with `resync_i`, and separately together with `bc_zero_i`. It then expects the pushed tag to carry zeros, and the following trigger to carry event 1 or the next bunch number. The almost-full rise and a trigger can also coincide. That case is provoked by raising `almost_full_i` on the trigger cycle. The judgement is that this trigger still reaches the front end, while the one on the next cycle becomes a null entry with `fe_trig_o` low.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int TRG_BC_W = 12;
    localparam int TRG_EC_W = 8;

    typedef struct packed {
        logic [TRG_BC_W-1:0] bc;
        logic [TRG_EC_W-1:0] ec;
        logic                nul;
    } trg_tag_t;
endpackage

// File: rtl/trg_bc_counter.sv
module trg_bc_counter #(
    parameter int BC_W      = 12,
    parameter int BC_PERIOD = 3564
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    output logic [BC_W-1:0] bc_o
);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BC_PERIOD - 1);

    logic [BC_W-1:0] bc_d, bc_q;

    always_comb begin
        bc_o = clr_i ? '0 : bc_q;
        bc_d = (bc_o == BC_LAST) ? '0 : bc_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bc_q <= '0;
        else        bc_q <= bc_d;
    end
endmodule

// File: rtl/trg_ec_counter.sv
module trg_ec_counter #(
    parameter int EC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            inc_i,
    output logic [EC_W-1:0] ec_o
);
    logic [EC_W-1:0] ec_d, ec_q;

    always_comb begin
        ec_o = clr_i ? '0 : ec_q;
        ec_d = ec_o + EC_W'(inc_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ec_q <= '0;
        else        ec_q <= ec_d;
    end
endmodule

// File: rtl/trig_gate_ctrl.sv
module trig_gate_ctrl
    import trg_pkg::*;
#(
    parameter int NFE       = 4,
    parameter int NAF       = 3,
    parameter int BC_PERIOD = 3564
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                l1a_i,
    input  logic                resync_i,
    input  logic                bc_zero_i,
    input  logic                inhibit_en_i,
    input  logic [NAF-1:0]      almost_full_i,
    input  logic                trigq_full_i,
    output logic [NFE-1:0]      fe_trig_o,
    output logic                push_o,
    output logic [TRG_BC_W-1:0] push_bc_o,
    output logic [TRG_EC_W-1:0] push_ec_o,
    output logic                push_null_o,
    output logic                inhibit_o,
    output logic                ovf_err_o
);
    typedef struct packed {
        logic [NFE-1:0] fe_trig;
        logic           push;
        trg_tag_t       tag;
        logic           inhibit;
        logic           ovf;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic [TRG_BC_W-1:0] bc_cur;
    logic [TRG_EC_W-1:0] ec_cur;

    trg_bc_counter #(.BC_W(TRG_BC_W), .BC_PERIOD(BC_PERIOD)) u_bc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (resync_i | bc_zero_i),
        .bc_o  (bc_cur)
    );

    trg_ec_counter #(.EC_W(TRG_EC_W)) u_ec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (resync_i),
        .inc_i (l1a_i),
        .ec_o  (ec_cur)
    );

    always_comb begin
        st_d         = st_q;
        st_d.inhibit = inhibit_en_i & (|almost_full_i);
        st_d.fe_trig = {NFE{l1a_i & ~st_q.inhibit}};
        st_d.push    = l1a_i;
        if (l1a_i) begin
            st_d.tag.bc  = bc_cur;
            st_d.tag.ec  = ec_cur;
            st_d.tag.nul = st_q.inhibit;
        end
        st_d.ovf = st_q.ovf | (l1a_i & ~inhibit_en_i & trigq_full_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fe_trig_o   = st_q.fe_trig;
    assign push_o      = st_q.push;
    assign push_bc_o   = st_q.tag.bc;
    assign push_ec_o   = st_q.tag.ec;
    assign push_null_o = st_q.tag.nul;
    assign inhibit_o   = st_q.inhibit;
    assign ovf_err_o   = st_q.ovf;
endmodule

// File: rtl/trg_gate_chk.sv
module trg_gate_chk #(
    parameter int NFE = 4,
    parameter int NAF = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           l1a_i,
    input logic           inhibit_en_i,
    input logic [NAF-1:0] almost_full_i,
    input logic           trigq_full_i,
    input logic [NFE-1:0] fe_trig_o,
    input logic           push_o,
    input logic           push_null_o,
    input logic           inhibit_o,
    input logic           ovf_err_o
);
    // R4
    push_follows_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o == $past(l1a_i));

    // R5
    fe_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fe_trig_o) |-> (push_o && !push_null_o && (&fe_trig_o)));

    // R7
    null_blocks_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && push_null_o) |-> (fe_trig_o == '0));

    // R6
    inhibit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o == $past(inhibit_en_i && (|almost_full_i)));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);

    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err_o) |-> $past(l1a_i && !inhibit_en_i && trigq_full_i));
endmodule

bind trig_gate_ctrl trg_gate_chk #(.NFE(NFE), .NAF(NAF)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .l1a_i         (l1a_i),
    .inhibit_en_i  (inhibit_en_i),
    .almost_full_i (almost_full_i),
    .trigq_full_i  (trigq_full_i),
    .fe_trig_o     (fe_trig_o),
    .push_o        (push_o),
    .push_null_o   (push_null_o),
    .inhibit_o     (inhibit_o),
    .ovf_err_o     (ovf_err_o)
);

// File: tb/tb_trig_gate_ctrl.sv
module tb_trig_gate_ctrl;
    localparam int NFE = 4;
    localparam int NAF = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           l1a_i = 1'b0, resync_i = 1'b0, bc_zero_i = 1'b0;
    logic           inhibit_en_i = 1'b0, trigq_full_i = 1'b0;
    logic [NAF-1:0] almost_full_i = '0;
    logic [NFE-1:0] fe_trig_o;
    logic           push_o, push_null_o, inhibit_o, ovf_err_o;
    logic [11:0]    push_bc_o;
    logic [7:0]     push_ec_o;

    int tests = 0, fails = 0, cyc = 0, exp_ec = 0;

    trig_gate_ctrl #(.NFE(NFE), .NAF(NAF)) dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        l1a_i = 0; resync_i = 0; bc_zero_i = 0;
        inhibit_en_i = 0; trigq_full_i = 0; almost_full_i = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq("R1 push", int'(push_o), 0);
        chk_eq("R1 fe", int'(fe_trig_o), 0);
        chk_eq("R1 inhibit", int'(inhibit_o), 0);
        chk_eq("R1 ovf", int'(ovf_err_o), 0);
        chk_eq("R1 tag", int'({push_bc_o, push_ec_o, push_null_o}), 0);
    endtask

    task automatic t_basic();
        // trigger coinciding with resync: tagged zeros (R3)
        resync_i = 1; l1a_i = 1;
        step();
        resync_i = 0; l1a_i = 0;
        chk_eq("R3 resync push", int'(push_o), 1);
        chk_eq("R3 resync ec", int'(push_ec_o), 0);
        chk_eq("R3 resync bc", int'(push_bc_o), 0);
        exp_ec = 1;
        step();
        chk_eq("R11 idle push", int'(push_o), 0);
        chk_eq("R11 idle fe", int'(fe_trig_o), 0);
        l1a_i = 1;
        step();
        l1a_i = 0;
        chk_eq("R4 ec next", int'(push_ec_o), exp_ec);
        chk_eq("R4 bc after resync", int'(push_bc_o), 2);
        chk_eq("R5 fe all", int'(fe_trig_o), 4'hF);
        chk_eq("R5 null", int'(push_null_o), 0);
        exp_ec++;
    endtask

    task automatic t_bc_wrap();
        // trigger on the bunch-zero cycle: bc 0, ec keeps counting (R3)
        bc_zero_i = 1; l1a_i = 1;
        step();
        bc_zero_i = 0; l1a_i = 0;
        chk_eq("R3 bc0 bc", int'(push_bc_o), 0);
        chk_eq("R3 bc0 ec kept", int'(push_ec_o), exp_ec);
        exp_ec++;
        for (int k = 1; k < 3563; k++) step();
        l1a_i = 1;
        step();
        chk_eq("R2 bc last", int'(push_bc_o), 3563);
        step();
        l1a_i = 0;
        chk_eq("R2 bc wrap", int'(push_bc_o), 0);
        chk_eq("R2 ec consecutive", int'(push_ec_o), exp_ec + 1);
        exp_ec += 2;
        step();
    endtask

    task automatic t_ec_wrap();
        resync_i = 1;
        step();
        resync_i = 0;
        l1a_i = 1;
        for (int i = 0; i < 258; i++) begin
            step();
            chk_eq("R4 ec seq", int'(push_ec_o), i % 256);
        end
        l1a_i = 0;
        step();
        exp_ec = 258 % 256;
    endtask

    task automatic t_inhibit();
        inhibit_en_i = 1;
        almost_full_i = 3'b010; l1a_i = 1;
        step();
        chk_eq("R8 same-cycle forwarded", int'(fe_trig_o), 4'hF);
        chk_eq("R8 not null", int'(push_null_o), 0);
        chk_eq("R6 inhibit up", int'(inhibit_o), 1);
        exp_ec++;
        step();
        l1a_i = 0;
        chk_eq("R7 fe gated", int'(fe_trig_o), 0);
        chk_eq("R7 push", int'(push_o), 1);
        chk_eq("R7 null", int'(push_null_o), 1);
        chk_eq("R7 ec advances", int'(push_ec_o), exp_ec);
        exp_ec++;
        almost_full_i = '0;
        step();
        chk_eq("R6 inhibit down", int'(inhibit_o), 0);
        l1a_i = 1;
        step();
        l1a_i = 0;
        chk_eq("R7 after drain fe", int'(fe_trig_o), 4'hF);
        chk_eq("R7 after drain ec", int'(push_ec_o), exp_ec);
        exp_ec++;
        step();
    endtask

    task automatic t_disabled();
        inhibit_en_i = 0; almost_full_i = 3'b111;
        step();
        l1a_i = 1;
        step();
        l1a_i = 0;
        chk_eq("R9 inhibit stays low", int'(inhibit_o), 0);
        chk_eq("R9 forwarded", int'(fe_trig_o), 4'hF);
        chk_eq("R9 not null", int'(push_null_o), 0);
        almost_full_i = '0;
        step();
    endtask

    task automatic t_ovf();
        inhibit_en_i = 1; trigq_full_i = 1; l1a_i = 1;
        step();
        l1a_i = 0;
        chk_eq("R10 enabled no ovf", int'(ovf_err_o), 0);
        inhibit_en_i = 0; l1a_i = 1;
        step();
        l1a_i = 0; trigq_full_i = 0;
        chk_eq("R10 ovf set", int'(ovf_err_o), 1);
        step(); step();
        chk_eq("R10 ovf sticky", int'(ovf_err_o), 1);
        do_reset();
        chk_eq("R1 ovf cleared by reset", int'(ovf_err_o), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_bc_wrap();
        t_ec_wrap();
        t_inhibit();
        t_disabled();
        t_ovf();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule